// File: doc/BRIEF.md
# ADC Register Access Engine

This block is a serial-peripheral-interface master that carries out one register transaction at a time with a sigma-delta converter. A transaction is a generated command byte followed by one, two or three data bytes. The requester presents the direction, a 3-bit register address, a byte count, a continuous-read flag, write data and a keep-select flag for one cycle. The block builds the command byte, shifts everything out most significant bit first in clock mode 3, and for reads collects the returned bytes into a right-aligned word.

Chip-select stays asserted for the whole transaction and is released at its end. When the keep-select flag is set, chip-select stays low after the last byte, so that the converter's data-out line can serve as a conversion-ready signal. The next transaction then runs without a new select edge. The serial clock is the system clock divided by a parameter. A request with a byte count outside 1..3 is refused with a one-cycle error pulse.

Top module: `adc_reg_xfer`

## Requirements
- R1: After reset, cs_n is 1, sclk is 1, mosi is 0, and done, err, busy and rdata are all 0.
- R2: The first byte shifted out is the command byte. Bit 7 is 0, bit 6 is the direction (1 read, 0 write), bits 5:3 are the register address, bit 2 is the continuous-read flag and bits 1:0 are 0.
- R3: In a write of N bytes, the low 8*N bits of req_wdata follow the command byte most significant bit first, within the same select period. Higher bits of req_wdata are not sent.
- R4: In a read, mosi is 0 during the data bytes. At done, rdata holds the returned bytes right-aligned, with the first byte received most significant and the unused upper bits 0. A write leaves rdata unchanged.
- R5: sclk idles high. Each bit holds sclk low for HALF_CYC clock cycles and then high for HALF_CYC cycles. mosi changes only as sclk falls, and miso is sampled as sclk rises.
- R6: cs_n goes low in the cycle the request is accepted and stays low until the last bit ends. It then goes high, unless keep-select was requested.
- R7: With keep-select set, cs_n stays low after done and through the next transaction. A later transaction without keep-select releases it at its end.
- R8: busy is high from acceptance until the transaction ends. done pulses for exactly one cycle as busy falls, 2*HALF_CYC*8*(N+1) cycles after the accepting edge.
- R9: A request with a byte count of 0 or greater than 3 starts no transaction. It pulses err for one cycle and leaves cs_n, sclk and busy unchanged.
- R10: A request presented while busy is ignored. It does not disturb the transaction in progress and does not start another one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_read | input | 1 | 1 for read, 0 for write |
| req_addr | input | 3 | Register address |
| req_nbytes | input | NB_W | Data byte count, legal 1..MAX_BYTES |
| req_cont | input | 1 | Continuous-read flag for the command byte |
| req_keep_sel | input | 1 | Keep chip-select low after the transaction |
| req_wdata | input | 8*MAX_BYTES | Write data, right-aligned |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | One-cycle illegal byte-count pulse |
| rdata | output | 8*MAX_BYTES | Right-aligned read result |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
The bench compares the serial pins against a timing model on every cycle. A divider with an off-by-one error would move the sclk edges against the model, and a shifter that launched on the rising edge would show mosi changing while sclk is high. Writes carry garbage in the unused upper bits of req_wdata, so a framer that does not truncate would send the wrong bits. Writes issued after a read check that rdata holds, and one-byte and two-byte reads check that the unused upper bits of rdata stay zero. Keep-select chains, an illegal count issued while select is held, and a request injected in the middle of a transfer check that chip-select is neither released early nor disturbed and that no phantom transaction starts.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } xfer_state_e;

   // Command layout: [7]=0 (write enable, active low), [6]=read, [5:3]=addr,
   // [2]=continuous read, [1:0]=0
   function automatic logic [7:0] make_cmd(input logic rd,
                                           input logic [2:0] addr,
                                           input logic cont);
      return {1'b0, rd, addr, cont, 2'b00};
   endfunction

endpackage

// File: rtl/adc_xfer_tick.sv
module adc_xfer_tick #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/adc_xfer_framer.sv
module adc_xfer_framer
   import adc_xfer_pkg::*;
#(
   parameter int MAX_BYTES = 3,
   parameter int NB_W      = 3,
   localparam int DW       = 8 * MAX_BYTES,
   localparam int TXW      = 8 + DW,
   localparam int BC_W     = $clog2(TXW + 1)
) (
   input  logic            rd,
   input  logic [2:0]      addr,
   input  logic            cont,
   input  logic [NB_W-1:0] nbytes,
   input  logic [DW-1:0]   wdata,
   output logic            ok,
   output logic [TXW-1:0]  tx_word,
   output logic [BC_W-1:0] nbits
);
   logic [DW-1:0] data_al;

   always_comb begin
      ok      = 1'b0;
      data_al = '0;
      nbits   = '0;
      for (int k = 1; k <= MAX_BYTES; k++) begin
         if (nbytes == NB_W'(k)) begin
            ok      = 1'b1;
            nbits   = BC_W'(8 * (k + 1));
            data_al = wdata << (8 * (MAX_BYTES - k));
         end
      end
      if (rd)
         data_al = '0;
      tx_word = {make_cmd(rd, addr, cont), data_al};
   end
endmodule

// File: rtl/adc_xfer_shreg.sv
module adc_xfer_shreg #(
   parameter int TXW = 32,
   parameter int DW  = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [TXW-1:0] load_word,
   input  logic           launch,
   input  logic           sample,
   input  logic           clear,
   input  logic           miso,
   output logic           mosi,
   output logic [DW-1:0]  rx
);
   logic [TXW-1:0] tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx   <= '0;
         mosi <= 1'b0;
      end else if (load) begin
         mosi <= load_word[TXW-1];
         tx   <= {load_word[TXW-2:0], 1'b0};
      end else if (launch) begin
         mosi <= tx[TXW-1];
         tx   <= {tx[TXW-2:0], 1'b0};
      end else if (clear) begin
         mosi <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx <= '0;
      else if (load)
         rx <= '0;
      else if (sample)
         rx <= {rx[DW-2:0], miso};
   end
endmodule

// File: rtl/adc_reg_xfer.sv
module adc_reg_xfer
   import adc_xfer_pkg::*;
#(
   parameter int MAX_BYTES = 3,
   parameter int NB_W      = 3,
   parameter int HALF_CYC  = 2,
   localparam int DW       = 8 * MAX_BYTES,
   localparam int TXW      = 8 + DW,
   localparam int BC_W     = $clog2(TXW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_read,
   input  logic [2:0]      req_addr,
   input  logic [NB_W-1:0] req_nbytes,
   input  logic            req_cont,
   input  logic            req_keep_sel,
   input  logic [DW-1:0]   req_wdata,
   output logic            busy,
   output logic            done,
   output logic            err,
   output logic [DW-1:0]   rdata,
   output logic            spi_sclk,
   output logic            spi_mosi,
   input  logic            spi_miso,
   output logic            spi_cs_n
);
   generate
      if (HALF_CYC < 1) begin : g_chk_half
         $error("HALF_CYC must be at least 1");
      end
      if (MAX_BYTES < 1) begin : g_chk_bytes
         $error("MAX_BYTES must be at least 1");
      end
      if ((2 ** NB_W) <= MAX_BYTES) begin : g_chk_nbw
         $error("NB_W too narrow for MAX_BYTES");
      end
   endgenerate

   xfer_state_e     state;
   logic            tick;
   logic            f_ok;
   logic [TXW-1:0]  f_word;
   logic [BC_W-1:0] f_nbits;
   logic [BC_W-1:0] bits_left;
   logic [NB_W-1:0] nb_q;
   logic            keep_q;
   logic            rd_q;
   logic [DW-1:0]   rx;
   logic [DW-1:0]   rd_mask;
   logic            s_load, s_launch, s_sample, s_last;

   adc_xfer_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state != ST_IDLE),
      .tick (tick)
   );

   adc_xfer_framer #(.MAX_BYTES(MAX_BYTES), .NB_W(NB_W)) u_framer (
      .rd     (req_read),
      .addr   (req_addr),
      .cont   (req_cont),
      .nbytes (req_nbytes),
      .wdata  (req_wdata),
      .ok     (f_ok),
      .tx_word(f_word),
      .nbits  (f_nbits)
   );

   assign s_load   = (state == ST_IDLE) && req_valid && f_ok;
   assign s_sample = (state == ST_LOW) && tick;
   assign s_last   = (state == ST_HIGH) && tick && (bits_left == '0);
   assign s_launch = (state == ST_HIGH) && tick && (bits_left != '0);

   adc_xfer_shreg #(.TXW(TXW), .DW(DW)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (s_load),
      .load_word(f_word),
      .launch   (s_launch),
      .sample   (s_sample),
      .clear    (s_last),
      .miso     (spi_miso),
      .mosi     (spi_mosi),
      .rx       (rx)
   );

   always_comb begin
      for (int i = 0; i < DW; i++)
         rd_mask[i] = (i < 8 * int'(nb_q));
   end

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         spi_cs_n  <= 1'b1;
         spi_sclk  <= 1'b1;
         done      <= 1'b0;
         err       <= 1'b0;
         rdata     <= '0;
         bits_left <= '0;
         nb_q      <= '0;
         keep_q    <= 1'b0;
         rd_q      <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (f_ok) begin
                     state     <= ST_LOW;
                     spi_cs_n  <= 1'b0;
                     spi_sclk  <= 1'b0;
                     bits_left <= f_nbits - BC_W'(1);
                     nb_q      <= req_nbytes;
                     keep_q    <= req_keep_sel;
                     rd_q      <= req_read;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            ST_LOW: begin
               if (tick) begin
                  spi_sclk <= 1'b1;
                  state    <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  if (bits_left == '0) begin
                     state    <= ST_IDLE;
                     spi_cs_n <= !keep_q;
                     done     <= 1'b1;
                     if (rd_q)
                        rdata <= rx & rd_mask;
                  end else begin
                     spi_sclk  <= 1'b0;
                     bits_left <= bits_left - BC_W'(1);
                     state     <= ST_LOW;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_xfer_chk.sv
module adc_xfer_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic err,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);
   // R5: serial clock parked high whenever no transfer runs
   p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_sclk);

   // R5: while busy, mosi moves only together with a falling sclk
   p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$stable(spi_mosi)) |-> $fell(spi_sclk));

   // R6: select held for the whole transfer
   p_cs_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !spi_cs_n);

   // R8: done is a single-cycle pulse outside busy
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R9: error is a single-cycle pulse that starts nothing and keeps select
   p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !done && $stable(spi_cs_n)));
endmodule

bind adc_reg_xfer adc_xfer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .spi_cs_n(spi_cs_n),
   .spi_sclk(spi_sclk),
   .spi_mosi(spi_mosi)
);

// File: tb/tb_adc_reg_xfer.sv
module tb_adc_reg_xfer;
   localparam int H = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_read = 1'b0, req_cont = 1'b0, req_keep_sel = 1'b0;
   logic [2:0]  req_addr = '0;
   logic [2:0]  req_nbytes = '0;
   logic [23:0] req_wdata = '0;
   logic        busy, done, err, spi_sclk, spi_mosi, spi_cs_n;
   logic        spi_miso = 1'b0;
   logic [23:0] rdata;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [23:0] exp_rd = '0;
   logic        exp_cs = 1'b1;

   always #5 clk = ~clk;

   adc_reg_xfer #(.MAX_BYTES(3), .NB_W(3), .HALF_CYC(H)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_addr(req_addr), .req_nbytes(req_nbytes), .req_cont(req_cont),
      .req_keep_sel(req_keep_sel), .req_wdata(req_wdata), .busy(busy),
      .done(done), .err(err), .rdata(rdata), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // One transaction, checked cycle by cycle against a timing model.
   task automatic xfer(input bit rd, input logic [2:0] addr, input int n,
                       input bit cont, input bit keep, input logic [23:0] wd,
                       input logic [31:0] stream, input bit inject);
      int nb = 8 * (n + 1);
      int total = nb * 2 * H;
      logic [31:0] tx;
      logic [23:0] mask;
      tx = {1'b0, rd, addr, cont, 2'b00, 24'h0};
      if (!rd) tx[23:0] = 24'(wd << (8 * (3 - n)));
      mask = 24'((32'h1 << (8 * n)) - 1);
      @(negedge clk);
      req_valid = 1; req_read = rd; req_addr = addr; req_nbytes = 3'(n);
      req_cont = cont; req_keep_sel = keep; req_wdata = wd;
      @(posedge clk);
      for (int c = 0; c <= total + 1; c++) begin
         @(negedge clk);
         if (c == 0) req_valid = 0;
         if (inject && c == 5) begin
            req_valid = 1; req_read = 1; req_addr = 3'd7; req_nbytes = 3'd1; req_keep_sel = 1;
         end
         if (inject && c == 6) req_valid = 0;
         if (c < total) begin
            int b = c / (2 * H);
            bit low = (c % (2 * H)) < H;
            chk("R5 sclk phase", spi_sclk, !low);
            chk("R6 cs held", spi_cs_n, 0);
            chk(inject ? "R10 busy kept" : "R8 busy", busy, 1);
            chk("R8 done low", done, 0);
            if (b < 8) chk("R2 command bit", spi_mosi, tx[31-b]);
            else if (rd) chk("R4 mosi low in read", spi_mosi, 0);
            else chk("R3 write bit", spi_mosi, tx[31-b]);
            spi_miso = stream[nb-1-b];
         end else if (c == total) begin
            if (rd) exp_rd = stream[23:0] & mask;
            exp_cs = !keep;
            chk("R8 done pulse", done, 1);
            chk("R8 busy end", busy, 0);
            chk("R5 sclk idle", spi_sclk, 1);
            chk("R4 mosi idle", spi_mosi, 0);
            chk(keep ? "R7 cs kept" : "R6 cs release", spi_cs_n, exp_cs);
            chk("R4 rdata", rdata, exp_rd);
         end else begin
            chk("R8 done single", done, 0);
            chk(inject ? "R10 no phantom" : "R8 idle", busy, 0);
            chk("R5 sclk idle", spi_sclk, 1);
            chk(keep ? "R7 cs kept" : "R6 cs idle", spi_cs_n, exp_cs);
         end
      end
   endtask

   task automatic bad(input int n);
      @(negedge clk);
      req_valid = 1; req_nbytes = 3'(n); req_read = 0; req_keep_sel = 0;
      @(negedge clk);
      req_valid = 0;
      chk("R9 err pulse", err, 1);
      chk("R9 not busy", busy, 0);
      chk("R9 cs unchanged", spi_cs_n, exp_cs);
      chk("R9 sclk idle", spi_sclk, 1);
      chk("R9 no done", done, 0);
      @(negedge clk);
      chk("R9 err single", err, 0);
      chk("R9 still idle", busy, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 cs_n", spi_cs_n, 1);
      chk("R1 sclk", spi_sclk, 1);
      chk("R1 mosi", spi_mosi, 0);
      chk("R1 done", done, 0);
      chk("R1 err", err, 0);
      chk("R1 busy", busy, 0);
      chk("R1 rdata", rdata, 0);

      xfer(0, 3'd1, 3, 0, 0, 24'hA5C33C, 32'h0, 0);
      xfer(1, 3'd4, 1, 0, 0, 24'h0, 32'h0000_B7A4, 0);
      xfer(1, 3'd3, 3, 1, 0, 24'h0, 32'hDEAD_BEEF, 0);
      xfer(1, 3'd6, 2, 0, 0, 24'h0, 32'h0012_C3F0, 1);
      xfer(0, 3'd2, 1, 0, 1, 24'hFFFF5A, 32'hFFFF_FFFF, 0);
      bad(0);
      xfer(0, 3'd7, 2, 1, 0, 24'h77BEEF, 32'h0, 0);
      bad(4);
      bad(7);
      xfer(1, 3'd5, 2, 0, 1, 24'h0, 32'h00AB_8001, 0);
      xfer(1, 3'd0, 1, 0, 0, 24'h0, 32'h0000_1E69, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule